// File: doc/BRIEF.md
# Transfer Byte Counter with End-of-Transfer Interrupt

This block is a register slice for a host controller that moves data between a host bus and an internal buffer memory. Software loads a 16-bit byte count and then starts the transfer with a separate start bit. From that point each byte-moved strobe lowers a remaining count. The strobe behaves the same whether the bytes move by programmed I/O or by DMA. When the remaining count reaches zero, the block raises an internal end-of-transfer event. The event pulses a buffer-status update output and sets a sticky end-of-transfer bit in an interrupt status register.

Status bits clear only when software writes a 1 to them. The interrupt pin is a level. It is the OR of every status bit whose enable bit is set, gated by a global interrupt enable. Registers are reached through a command-coded port. The write code of a register is its read code with bit 7 set: global enable 20h/A0h, start control 21h/A1h, byte count 22h/A2h, remaining count 23h (read only), status 24h/A4h and enables 25h/A5h.

Top module: `xfer_count_irq`

## Requirements
- R1: After reset, every readable register reads 0, and both irq and buf_upd are low.
- R2: A write to code A2h stores all 16 bits of the byte count, and a read at 22h returns them.
- R3: A register write happens only when reg_wr is high and reg_cmd bit 7 is set. A write strobe with a code whose bit 7 is clear (for example 22h) changes nothing.
- R4: Writing A1h with data bit 7 high arms the counter and loads the remaining count (read at 23h) from the byte count. Writing the byte count alone leaves the remaining count unchanged. Bit 7 of a read at 21h shows the armed state.
- R5: While the counter is armed and the remaining count is nonzero, each byte_stb cycle lowers the remaining count by one. While the counter is not armed, byte_stb has no effect.
- R6: When the counter is armed and the remaining count is zero, the following happen together. buf_upd is high for exactly one cycle. At the next clock edge, status bit 2 sets and the armed state clears. Strobes that follow do not change the count.
- R7: Arming with a byte count of zero raises the end-of-transfer at once, with no byte strobe needed.
- R8: Status bits are sticky. A write to A4h clears each bit whose data bit is 1 and leaves the others. Writing FFh clears bits 7 to 0.
- R9: If an end-of-transfer and a write-one-to-clear hit status bit 2 in the same cycle, the bit ends up set.
- R10: irq is high exactly when bit 0 of the global enable register is set and at least one status bit is set with its enable bit (written at A5h) also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_cmd | input | 8 | Register command code; bit 7 set means write |
| reg_wr | input | 1 | Write strobe for the code on reg_cmd |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the code on reg_cmd (combinational) |
| byte_stb | input | 1 | One byte moved this cycle |
| buf_upd | output | 1 | One-cycle buffer-status update pulse on end-of-transfer |
| irq | output | 1 | Level interrupt output |

## Verification
The bench runs transfers that stop short of the count, land exactly on it, and overshoot it. A counter that failed to stop would wrap below zero, and one that ignored the start bit would show no reload. It arms a count of zero: a design that waits for a strobe never pulses buf_upd. It lines up a write-one-to-clear with the end-of-transfer cycle: a design where clear wins loses the event. It walks the enable and global-enable combinations: a design that skipped either gate would assert irq when it should stay low.

// File: rtl/xfer_count_irq.sv
module xfer_count_irq #(
  parameter int CW = 16,
  parameter int SW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    reg_cmd,
  input  logic          reg_wr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          byte_stb,
  output logic          buf_upd,
  output logic          irq
);
  localparam logic [6:0] A_GEN = 7'h20;
  localparam logic [6:0] A_CTL = 7'h21;
  localparam logic [6:0] A_CNT = 7'h22;
  localparam logic [6:0] A_REM = 7'h23;
  localparam logic [6:0] A_STS = 7'h24;
  localparam logic [6:0] A_ENA = 7'h25;
  localparam int EOT_BIT = 2;

  logic [CW-1:0] cnt, rem;
  logic [SW-1:0] sts, ena, sts_set, sts_clr;
  logic          gen, active;

  wire       wr_hit = reg_wr & reg_cmd[7];
  wire [6:0] addr   = reg_cmd[6:0];
  wire       arm    = wr_hit && addr == A_CTL && reg_wdata[7];
  wire       eot    = active && rem == '0;

  assign buf_upd = eot;
  assign irq     = gen & |(sts & ena);

  always_comb begin
    sts_set          = '0;
    sts_set[EOT_BIT] = eot;
    sts_clr          = (wr_hit && addr == A_STS) ? reg_wdata[SW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      rem    <= '0;
      sts    <= '0;
      ena    <= '0;
      gen    <= 1'b0;
      active <= 1'b0;
    end else begin
      if (wr_hit && addr == A_CNT) cnt <= reg_wdata;
      if (wr_hit && addr == A_GEN) gen <= reg_wdata[0];
      if (wr_hit && addr == A_ENA) ena <= reg_wdata[SW-1:0];
      if (arm) begin
        rem    <= cnt;
        active <= 1'b1;
      end else if (eot) begin
        active <= 1'b0;
      end else if (active && byte_stb) begin
        rem <= rem - 1'b1;
      end
      sts <= (sts & ~sts_clr) | sts_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (!reg_cmd[7]) begin
      case (addr)
        A_GEN:   reg_rdata[0] = gen;
        A_CTL:   reg_rdata[7] = active;
        A_CNT:   reg_rdata = cnt;
        A_REM:   reg_rdata = rem;
        A_STS:   reg_rdata[SW-1:0] = sts;
        A_ENA:   reg_rdata[SW-1:0] = ena;
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/xfer_count_irq_chk.sv
module xfer_count_irq_chk #(
  parameter int CW = 16,
  parameter int SW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    reg_cmd,
  input logic          reg_wr,
  input logic [CW-1:0] reg_wdata,
  input logic          byte_stb,
  input logic          buf_upd,
  input logic          irq,
  input logic [CW-1:0] rem,
  input logic [SW-1:0] sts,
  input logic [SW-1:0] ena,
  input logic          gen,
  input logic          active
);
  wire arm_w = reg_wr && reg_cmd == 8'hA1 && reg_wdata[7];
  wire clr2  = reg_wr && reg_cmd == 8'hA4 && reg_wdata[2];

  p_upd_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_upd && !arm_w |=> !buf_upd);
  p_eot_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_upd |=> sts[2]);
  p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active && byte_stb && rem != '0 && !arm_w |=> rem == $past(rem) - 1'b1);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active && !arm_w |=> $stable(rem));
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sts[2] && !clr2 |=> sts[2]);
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gen |-> !irq);
  p_need_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sts & ena) == '0 |-> !irq);
endmodule

bind xfer_count_irq xfer_count_irq_chk #(.CW(CW), .SW(SW)) u_chk (.*);

// File: tb/sim_xfer_count_irq.sv
`timescale 1ns/1ps
module sim_xfer_count_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_cmd = 8'h00;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        byte_stb = 1'b0;
  logic        buf_upd, irq;
  int checks = 0, fails = 0, upd_seen = 0;

  always #10 clk = ~clk;

  xfer_count_irq u0 (.clk, .rst_n, .reg_cmd, .reg_wr, .reg_wdata, .reg_rdata,
                     .byte_stb, .buf_upd, .irq);

  always @(negedge clk) if (rst_n && buf_upd) upd_seen++;

  // {count, strobes}
  localparam logic [31:0] VEC [6] = '{
    {16'd3,   16'd3},
    {16'd5,   16'd2},
    {16'd1,   16'd1},
    {16'd0,   16'd0},
    {16'd2,   16'd6},
    {16'd300, 16'd300}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] c, logic [15:0] d);
    @(negedge clk); reg_cmd = c; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0; reg_cmd = 8'h00;
  endtask

  task automatic rd(logic [7:0] c, output logic [15:0] d);
    reg_cmd = c; #1; d = reg_rdata; reg_cmd = 8'h00;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_stb = 1'b1;
    end
    @(negedge clk); byte_stb = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int u0s;
    idle(3);
    // R1 reset state
    for (int a = 8'h20; a <= 8'h25; a++) begin
      rd(a[7:0], d); chk("R1 reg", d, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 buf_upd", buf_upd, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(1);

    // table walk: R4 R5 R6 R7
    foreach (VEC[i]) begin
      logic [15:0] c, n;
      c = VEC[i][31:16]; n = VEC[i][15:0];
      wr(8'hA4, 16'hFFFF);
      u0s = upd_seen;
      wr(8'hA2, c);
      wr(8'hA1, 16'h0080);
      if (n != 0) strobes(n);
      idle(3);
      rd(8'h23, d); chk("R5 remaining", d, (c > n) ? c - n : 0);
      rd(8'h24, d); chk("R6 eot status", d[2], (n >= c) ? 1 : 0);
      chk("R6 single pulse", upd_seen - u0s, (n >= c) ? 1 : 0);
      rd(8'h21, d); chk("R4 armed flag", d[7], (n >= c) ? 0 : 1);
    end

    // R2 full width readback
    wr(8'hA2, 16'hA5C3);
    rd(8'h22, d); chk("R2 count", d, 16'hA5C3);
    // R4 count write alone leaves remaining (3 from last row? last row ended at 0)
    rd(8'h23, d); chk("R4 no reload", d, 0);
    // R3 write strobe with bit 7 clear
    wr(8'h22, 16'h1111);
    rd(8'h22, d); chk("R3 no write", d, 16'hA5C3);
    // R5 strobes while idle ignored
    wr(8'hA2, 16'd4); wr(8'hA1, 16'h0080); strobes(4); idle(2);
    strobes(3);
    rd(8'h23, d); chk("R5 idle ignore", d, 0);

    // R7 zero count fires on arming
    wr(8'hA4, 16'hFFFF);
    wr(8'hA2, 16'd0);
    @(negedge clk); reg_cmd = 8'hA1; reg_wdata = 16'h0080; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    chk("R7 immediate eot", buf_upd, 1);
    idle(1);
    rd(8'h24, d); chk("R7 status", d[2], 1);

    // R9 set beats clear
    wr(8'hA4, 16'h0004);
    @(negedge clk); reg_cmd = 8'hA1; reg_wdata = 16'h0080; reg_wr = 1'b1;
    @(negedge clk); reg_cmd = 8'hA4; reg_wdata = 16'h0004;
    chk("R9 eot cycle", buf_upd, 1);
    @(negedge clk); reg_wr = 1'b0;
    rd(8'h24, d); chk("R9 set wins", d[2], 1);

    // R8 sticky and write-one-to-clear
    wr(8'hA4, 16'h0000);
    rd(8'h24, d); chk("R8 write 0 keeps", d[2], 1);
    wr(8'hA4, 16'h0004);
    rd(8'h24, d); chk("R8 write 1 clears", d[2], 0);
    wr(8'hA2, 16'd0); wr(8'hA1, 16'h0080); idle(1);
    wr(8'hA4, 16'h00FF);
    rd(8'h24, d); chk("R8 FFh clears", d, 0);

    // R10 interrupt gating
    wr(8'hA1, 16'h0080); idle(1);
    chk("R10 no enables", irq, 0);
    wr(8'hA5, 16'h0004); idle(1);
    chk("R10 no global", irq, 0);
    wr(8'hA0, 16'h0001); idle(1);
    chk("R10 asserted", irq, 1);
    rd(8'h20, d); chk("R3 global readback", d, 1);
    wr(8'hA5, 16'h0301); idle(1);
    chk("R10 other enable", irq, 0);
    wr(8'hA5, 16'h0004); idle(1);
    chk("R10 level held", irq, 1);
    wr(8'hA4, 16'h0004); idle(1);
    chk("R10 cleared", irq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule